// File: doc/BRIEF.md
# HDLC Frame Transmitter

This block turns tagged bytes into a bit-oriented HDLC line signal for a slow signalling channel. A producer writes bytes into a small transmit queue. Each byte carries a two-bit tag that says whether it is an ordinary byte, the final byte of a frame, or an abort marker. The serializer wraps each frame in 0x7E flags. It inserts a zero after every run of five ones inside the frame body and appends a 16-bit frame check sequence. Between frames it fills the line with either repeated flags or a steady mark of ones.

The line advances one bit for each cycle in which `bit_en` is high, so the surrounding logic sets the line rate. When a collision is reported during a frame, the rest of that frame is quietly pulled out of the queue while the line stays at ones. An underrun in the middle of a frame turns into an abort and raises a one-cycle status pulse. The block also has a start-up quirk. If flag fill is already selected when the transmitter is switched on, the first frame loses its opening flag, so that frame is drained and never appears on the line.

Top module: `hdlc_tx`

## Requirements
- R1: After reset `tx_bit` is 1. `tx_bit` changes only in the clock cycle that follows a cycle with `bit_en` high. While `tx_enable` is low, the line carries only ones once the current 8-bit idle unit has finished.
- R2: A frame is sent as: one 0x7E flag, the frame bytes in write order, the FCS, then one 0x7E flag. Every byte is sent least significant bit first. A frame starts only at the end of an 8-bit idle unit.
- R3: Inside the frame bytes and the FCS, a 0 is inserted after every five consecutive 1 bits. Flags, idle fill and the abort sequence are never stuffed.
- R4: The FCS is built as follows. The register starts at 0xFFFF. Every frame bit is processed LSB first with x^16+x^12+x^5+1 (reflected constant 0x8408). The ones complement of the result is sent, low byte first. Run over the frame bytes plus the FCS, this CRC leaves the remainder 0xF0B8.
- R5: The queue holds 19 entries. `fifo_full` is high while all 19 are in use, and a write while full is dropped. Tag encoding: 0 means normal, 1 means last byte of the frame, and 2 or 3 means abort.
- R6: With `flag_fill` high (and the transmitter enabled), the line between frames carries back-to-back 0x7E flags. With `flag_fill` low it carries continuous ones.
- R7: An abort-tagged byte is not sent. In place of that byte, the FCS and the closing flag, the block sends eight unstuffed ones.
- R8: If the queue is empty when the next byte of an unfinished frame is needed, the block sends the abort sequence. It then pulses `underrun` high for exactly one clock cycle.
- R9: When `collision` is high during the opening flag, the frame bytes or the FCS, the line goes to ones from the next bit onward. All bytes of that frame that are still queued, up to and including its last-byte or abort tag, are removed. They are never sent.
- R10: When `tx_enable` rises while `flag_fill` is high, the first frame that follows is removed from the queue without being sent. Frames after it are sent normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one tagged byte into the queue |
| wr_data | input | 8 | Byte to queue |
| wr_tag | input | 2 | 0 normal, 1 last byte of frame, 2/3 abort |
| fifo_full | output | 1 | Queue holds 19 entries |
| tx_enable | input | 1 | Transmitter enable |
| flag_fill | input | 1 | Idle fill select: 1 flags, 0 ones |
| bit_en | input | 1 | Advance the line by one bit |
| collision | input | 1 | Channel collision seen during a frame |
| tx_bit | output | 1 | Registered serial line output |
| underrun | output | 1 | One-cycle pulse when a frame is aborted for lack of data |

## Verification
The bench decodes the line with its own flag, abort and destuffing receiver and compares every frame against the queued bytes and the CRC remainder. A design that mishandled stuffing next to a closing flag, or after 0xFF and 0x7E data, would show up as a misaligned or malformed frame. The bench also targets these cases:
- A write into a full queue. A design that accepted it would emit an extra one-byte frame.
- An abort tag and a mid-frame underrun. Both must end in a run of ones with no closing flag and, for the underrun, exactly one pulse.
- A collision. If the drain were incomplete, the leftover bytes would show up as a stray frame ahead of the next real one.
- Enabling with flag fill already selected. A design without the quirk would send a frame that the bench does not expect.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int BYTE_W = 8;
  localparam int TAG_W  = 2;
  localparam int CRC_W  = 16;

  localparam logic [TAG_W-1:0]  TAG_NORM  = 2'd0;
  localparam logic [TAG_W-1:0]  TAG_LAST  = 2'd1;
  localparam logic [BYTE_W-1:0] FLAG_BYTE = 8'h7E;
  localparam logic [BYTE_W-1:0] MARK_BYTE = 8'hFF;
  localparam logic [CRC_W-1:0]  CRC_INIT  = 16'hFFFF;
  localparam logic [CRC_W-1:0]  CRC_POLY  = 16'h8408;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPEN, ST_DATA, ST_FCS_LO, ST_FCS_HI, ST_CLOSE, ST_ABORT, ST_DRAIN
  } st_e;
endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int DEPTH = 19,
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;
  logic             wr_ok, rd_ok;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign wr_ok = push && !full;
  assign rd_ok = pop && !empty;
  assign dout  = mem[rp_q];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
      if (rd_ok) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc import hdlc_tx_pkg::*; (
  input  logic [CRC_W-1:0] crc_in,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc_out
);
  logic fb;
  assign fb      = crc_in[0] ^ bit_in;
  assign crc_out = (crc_in >> 1) ^ (fb ? CRC_POLY : '0);
endmodule

// File: rtl/hdlc_tx_ser.sv
module hdlc_tx_ser import hdlc_tx_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              tx_enable,
  input  logic              flag_fill,
  input  logic              collision,
  input  logic              fifo_empty,
  input  logic [BYTE_W-1:0] fifo_data,
  input  logic [TAG_W-1:0]  fifo_tag,
  output logic              pop,
  output logic              tx_bit,
  output logic              underrun,
  output st_e               state,
  output logic              stuff_due
);
  st_e               st_q;
  logic [BYTE_W-1:0] sh_q, fcs_hi_q;
  logic [2:0]        cnt_q, ones_q;
  logic [CRC_W-1:0]  crc_q, crc_nx;
  logic              last_q, skip_q, en_q, tx_q, und_q;
  logic              counted, boundary, coll_hit, tag_abort, tag_last;

  hdlc_tx_crc u_crc (.crc_in(crc_q), .bit_in(sh_q[0]), .crc_out(crc_nx));

  assign stuff_due = (ones_q == 3'd5);
  assign counted   = st_q inside {ST_DATA, ST_FCS_LO, ST_FCS_HI};
  assign boundary  = bit_en && !stuff_due && (cnt_q == 3'd7);
  assign coll_hit  = collision && (st_q inside {ST_OPEN, ST_DATA, ST_FCS_LO, ST_FCS_HI});
  assign tag_abort = fifo_tag[1];
  assign tag_last  = (fifo_tag == TAG_LAST);
  assign tx_bit    = tx_q;
  assign underrun  = und_q;
  assign state     = st_q;

  always_comb begin
    pop = 1'b0;
    if (st_q == ST_DRAIN) pop = !fifo_empty;
    else if (boundary && !coll_hit) begin
      if (st_q == ST_OPEN)      pop = !fifo_empty;
      else if (st_q == ST_DATA) pop = !last_q && !fifo_empty;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      sh_q     <= MARK_BYTE;
      fcs_hi_q <= '0;
      cnt_q    <= '0;
      ones_q   <= '0;
      crc_q    <= CRC_INIT;
      last_q   <= 1'b0;
      skip_q   <= 1'b0;
      en_q     <= 1'b0;
      tx_q     <= 1'b1;
      und_q    <= 1'b0;
    end else begin
      en_q  <= tx_enable;
      und_q <= 1'b0;
      if (!tx_enable)                     skip_q <= 1'b0;
      else if (!en_q && flag_fill)        skip_q <= 1'b1;

      if (coll_hit) begin
        st_q   <= (last_q || st_q inside {ST_FCS_LO, ST_FCS_HI}) ? ST_IDLE : ST_DRAIN;
        sh_q   <= MARK_BYTE;
        cnt_q  <= '0;
        ones_q <= '0;
      end else if (st_q == ST_DRAIN) begin
        if (bit_en) tx_q <= 1'b1;
        if (!fifo_empty && fifo_tag != TAG_NORM) begin
          st_q  <= ST_IDLE;
          sh_q  <= MARK_BYTE;
          cnt_q <= '0;
        end
      end else if (bit_en) begin
        if (stuff_due) begin
          tx_q   <= 1'b0;
          ones_q <= '0;
        end else begin
          tx_q   <= sh_q[0];
          sh_q   <= {1'b1, sh_q[BYTE_W-1:1]};
          cnt_q  <= cnt_q + 3'd1;
          ones_q <= (counted && sh_q[0]) ? ones_q + 3'd1 : '0;
          if (st_q == ST_DATA) crc_q <= crc_nx;
          if (cnt_q == 3'd7) begin
            case (st_q)
              ST_OPEN: begin
                crc_q <= CRC_INIT;
                if (fifo_empty || tag_abort) begin
                  st_q  <= ST_ABORT;
                  sh_q  <= MARK_BYTE;
                  und_q <= fifo_empty;
                end else begin
                  st_q   <= ST_DATA;
                  sh_q   <= fifo_data;
                  last_q <= tag_last;
                end
              end
              ST_DATA: begin
                if (last_q) begin
                  st_q     <= ST_FCS_LO;
                  sh_q     <= ~crc_nx[BYTE_W-1:0];
                  fcs_hi_q <= ~crc_nx[CRC_W-1:BYTE_W];
                end else if (fifo_empty || tag_abort) begin
                  st_q  <= ST_ABORT;
                  sh_q  <= MARK_BYTE;
                  und_q <= fifo_empty;
                end else begin
                  sh_q   <= fifo_data;
                  last_q <= tag_last;
                end
              end
              ST_FCS_LO: begin
                st_q <= ST_FCS_HI;
                sh_q <= fcs_hi_q;
              end
              ST_FCS_HI: begin
                st_q <= ST_CLOSE;
                sh_q <= FLAG_BYTE;
              end
              default: begin
                if (en_q && !fifo_empty) begin
                  if (skip_q) begin
                    st_q   <= ST_DRAIN;
                    sh_q   <= MARK_BYTE;
                    skip_q <= 1'b0;
                  end else begin
                    st_q   <= ST_OPEN;
                    sh_q   <= FLAG_BYTE;
                    last_q <= 1'b0;
                  end
                end else begin
                  st_q <= ST_IDLE;
                  sh_q <= (en_q && flag_fill) ? FLAG_BYTE : MARK_BYTE;
                end
              end
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_tx.sv
module hdlc_tx import hdlc_tx_pkg::*; #(
  parameter int FIFO_DEPTH = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [TAG_W-1:0]  wr_tag,
  output logic              fifo_full,
  input  logic              tx_enable,
  input  logic              flag_fill,
  input  logic              bit_en,
  input  logic              collision,
  output logic              tx_bit,
  output logic              underrun
);
  localparam int ENTRY_W = BYTE_W + TAG_W;

  logic [ENTRY_W-1:0] rd_entry;
  logic               fifo_pop, fifo_empty, ser_stuff;
  st_e                ser_state;

  hdlc_tx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(ENTRY_W)) u_fifo (
    .clk(clk), .rst(rst), .push(wr_en), .din({wr_tag, wr_data}),
    .pop(fifo_pop), .dout(rd_entry), .empty(fifo_empty), .full(fifo_full)
  );

  hdlc_tx_ser u_ser (
    .clk(clk), .rst(rst), .bit_en(bit_en), .tx_enable(tx_enable),
    .flag_fill(flag_fill), .collision(collision), .fifo_empty(fifo_empty),
    .fifo_data(rd_entry[BYTE_W-1:0]), .fifo_tag(rd_entry[ENTRY_W-1:BYTE_W]),
    .pop(fifo_pop), .tx_bit(tx_bit), .underrun(underrun),
    .state(ser_state), .stuff_due(ser_stuff)
  );
endmodule

// File: rtl/hdlc_tx_chk.sv
module hdlc_tx_chk import hdlc_tx_pkg::*; (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic collision,
  input logic tx_bit,
  input logic underrun,
  input logic fifo_full,
  input logic pop,
  input logic empty,
  input logic stuff,
  input st_e  st
);
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(tx_bit)); // R1
  AST_STUFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bit_en && stuff && !collision) |=> !tx_bit); // R3
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty); // R5
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && !pop) |=> fifo_full); // R5
  AST_UNDERRUN_ABORT: assert property (@(posedge clk) disable iff (rst)
    underrun |-> (st == ST_ABORT)); // R8
  AST_DRAIN_MARK: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DRAIN && bit_en) |=> tx_bit); // R9
endmodule

bind hdlc_tx hdlc_tx_chk u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .collision(collision), .tx_bit(tx_bit),
  .underrun(underrun), .fifo_full(fifo_full), .pop(fifo_pop), .empty(fifo_empty),
  .stuff(ser_stuff), .st(ser_state)
);

// File: tb/test_hdlc_tx.sv
module test_hdlc_tx;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]   kind;   // 0 good frame, 1 abort, 2 malformed, 3 bad CRC
    logic [7:0]   len;
    logic [255:0] data;
  } ev_t;

  logic clk = 0, rst = 1, wr_en = 0, tx_enable = 0, flag_fill = 0, bit_en = 0, collision = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] wr_tag = 0;
  logic fifo_full, tx_bit, underrun;

  hdlc_tx i_hdlc_tx (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_tag(wr_tag),
    .fifo_full(fifo_full), .tx_enable(tx_enable), .flag_fill(flag_fill), .bit_en(bit_en),
    .collision(collision), .tx_bit(tx_bit), .underrun(underrun));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, ev_cnt = 0, flag_cnt = 0, und_cnt = 0, ones = 0;
  logic in_fr = 0, take = 0;
  logic [15:0] hist = 0;
  bit rx_bits[$];
  ev_t exp_q[$];
  logic [7:0] pay [0:31];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) r = (r >> 1) ^ ((r[0] ^ b[i]) ? 16'h8408 : 16'h0);
    return r;
  endfunction

  task automatic post_event(input ev_t got);
    ev_t e;
    ev_cnt++;
    if (exp_q.size() == 0) begin
      check(0, "R2", "unexpected line event kind", 64'(got.kind), 64'hF);
    end else begin
      e = exp_q.pop_front();
      check(got.kind == e.kind, "R2", "event kind", 64'(got.kind), 64'(e.kind));
      check(got.len == e.len && got.data == e.data, "R4", "frame length/data",
            {got.len, got.data[55:0]}, {e.len, e.data[55:0]});
    end
  endtask

  task automatic end_frame(input int n);
    ev_t g = '0;
    logic [15:0] c = 16'hFFFF;
    logic [7:0] b;
    if (n % 8 != 0 || n < 32) g.kind = 2'd2;
    else begin
      for (int k = 0; k < n / 8; k++) begin
        for (int j = 0; j < 8; j++) b[j] = rx_bits[k*8 + j];
        c = crc_byte(c, b);
        if (k < n / 8 - 2) g.data[k*8 +: 8] = b;
      end
      g.len  = 8'(n / 8 - 2);
      g.kind = (c == 16'hF0B8) ? 2'd0 : 2'd3;
    end
    post_event(g);
  endtask

  task automatic rx_bit(input logic b);
    ev_t g = '0;
    hist = {hist[14:0], b};
    if (b) begin
      ones++;
      rx_bits.push_back(1'b1);
      if (ones == 7) begin
        if (in_fr && rx_bits.size() > 7) begin g.kind = 2'd1; post_event(g); end
        in_fr = 0;
        rx_bits.delete();
      end
    end else begin
      if (ones == 6) begin
        flag_cnt++;
        if (in_fr && rx_bits.size() > 7) end_frame(rx_bits.size() - 7);
        in_fr = 1;
        rx_bits.delete();
      end else if (ones != 5) rx_bits.push_back(1'b0);
      ones = 0;
    end
  endtask

  // monitor: sample the line away from the clock edge after each enabled bit
  always @(posedge clk) take <= !rst && bit_en;
  always @(negedge clk) begin
    if (take) rx_bit(tx_bit);
    if (!rst && underrun) und_cnt++;
  end

  always @(negedge clk) begin
    if (rst) bit_en <= 1'b0;
    else     bit_en <= ~bit_en;
  end

  task automatic push_byte(input logic [7:0] d, input logic [1:0] t);
    @(negedge clk);
    wr_en = 1; wr_data = d; wr_tag = t;
    @(negedge clk);
    wr_en = 0;
  endtask

  // expect: 0 good frame, 1 abort, 2 nothing on the line
  task automatic write_frame(input int n, input logic [1:0] endtag, input int expect_kind);
    ev_t e = '0;
    if (expect_kind == 0) begin
      e.len = 8'(n);
      for (int i = 0; i < n; i++) e.data[i*8 +: 8] = pay[i];
      exp_q.push_back(e);
    end else if (expect_kind == 1) begin
      e.kind = 2'd1;
      exp_q.push_back(e);
    end
    for (int i = 0; i < n; i++) push_byte(pay[i], (i == n - 1) ? endtag : 2'd0);
  endtask

  task automatic fill_pay(input int seed);
    for (int i = 0; i < 32; i++) pay[i] = 8'(i * 29 + seed * 7 + 3);
  endtask

  task automatic wait_done(input string req);
    int g = 0;
    while (exp_q.size() != 0 && g < 20000) begin @(negedge clk); g++; end
    check(exp_q.size() == 0, req, "expected events still pending", 64'(exp_q.size()), 0);
    repeat (60) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int f0, e0, u0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(tx_bit == 1'b1, "R1", "line after reset", 64'(tx_bit), 1);
    repeat (40) @(negedge clk);
    check(hist == 16'hFFFF, "R1", "line while disabled", 64'(hist), 64'hFFFF);

    // R5: fill the queue, overflow write must be dropped
    fill_pay(1);
    write_frame(19, 2'd1, 0);
    check(fifo_full == 1'b1, "R5", "full after 19 writes", 64'(fifo_full), 1);
    push_byte(8'hAA, 2'd1);
    check(fifo_full == 1'b1, "R5", "full after dropped write", 64'(fifo_full), 1);
    tx_enable = 1;
    wait_done("R5");
    check(fifo_full == 1'b0, "R5", "queue emptied", 64'(fifo_full), 0);

    // R2 R3 R4: stuffing-heavy payload and a minimum frame
    pay[0] = 8'hFF; pay[1] = 8'hFF; pay[2] = 8'h7E; pay[3] = 8'h3F; pay[4] = 8'hF8; pay[5] = 8'h1F;
    write_frame(6, 2'd1, 0);
    wait_done("R3");
    fill_pay(5);
    write_frame(2, 2'd1, 0);
    wait_done("R2");

    // R6: idle fill patterns
    flag_fill = 1;
    f0 = flag_cnt;
    repeat (80) @(negedge clk);
    check(flag_cnt - f0 >= 3, "R6", "flags in flag fill", 64'(flag_cnt - f0), 3);
    fill_pay(9);
    write_frame(5, 2'd1, 0);
    wait_done("R6");
    flag_fill = 0;
    repeat (40) @(negedge clk);
    check(hist == 16'hFFFF, "R6", "mark idle", 64'(hist), 64'hFFFF);

    // R7: abort-tagged byte
    fill_pay(11);
    write_frame(3, 2'd2, 1);
    wait_done("R7");

    // R8: underrun mid frame
    u0 = und_cnt;
    fill_pay(13);
    write_frame(2, 2'd0, 1);
    wait_done("R8");
    check(und_cnt - u0 == 1, "R8", "underrun pulses", 64'(und_cnt - u0), 1);

    // R9: collision drains the rest of the frame
    fill_pay(17);
    begin ev_t e = '0; e.kind = 2'd1; exp_q.push_back(e); end
    write_frame(10, 2'd1, 2);
    repeat (60) @(negedge clk);
    collision = 1;
    @(negedge clk);
    collision = 0;
    repeat (20) @(negedge clk);
    check(hist[7:0] == 8'hFF, "R9", "line after collision", 64'(hist[7:0]), 64'hFF);
    fill_pay(19);
    write_frame(3, 2'd1, 0);
    wait_done("R9");

    // R10: enable with flag fill already selected loses the first frame
    tx_enable = 0;
    flag_fill = 1;
    repeat (40) @(negedge clk);
    fill_pay(23);
    write_frame(4, 2'd1, 2);
    e0 = ev_cnt;
    tx_enable = 1;
    repeat (200) @(negedge clk);
    check(ev_cnt == e0, "R10", "events from lost frame", 64'(ev_cnt - e0), 0);
    check(fifo_full == 1'b0, "R10", "queue not stuck full", 64'(fifo_full), 0);
    fill_pay(29);
    write_frame(7, 2'd1, 0);
    wait_done("R10");

    finish_run();
  end
endmodule